// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This controller moves a processor core into and out of exception handlers. When the core raises an exception request with an 8-bit vector number, the block saves the program counter and the status register to a supervisor stack. It then reads the handler address from a vector table and loads it into the program counter.

On a return request it pops the status register and program counter back from the stack top. After reset, or on a synchronous reset request, it runs an initialization sequence. That sequence forces the status register to its reset value and loads the supervisor stack pointer and the program counter from the first two vector slots.

All memory traffic goes through one 16-bit word port, which uses a combinational read. A 32-bit quantity takes two consecutive word accesses, with the high word at the lower address. The stack frame is three words: the status register at the lowest address, then the PC high word, then the PC low word.

Top module: `exc_seq`

## Requirements
- R1: While rst_ni is low, sr_o is 16'h2700 and busy_o is high. After release, busy_o stays high for exactly 4 cycles. These cycles read words at byte addresses 0 and 2 into ssp_o (high word first), then at 4 and 6 into pc_o, after which busy_o drops.
- R2: When an exception is accepted, sr_o bit 13 (supervisor) becomes 1 and bit 15 (trace) becomes 0 on the next clock edge. All other bits keep their values.
- R3: Entry with stack pointer X writes three words: the PC high word to X-4, the PC low word to X-2, and the pre-entry SR to X-6. After entry ssp_o equals X-6, and mem_we_o is only ever high while busy_o is high.
- R4: The handler address is read from byte address vector*4 (high word) and vector*4+2 (low word) and loaded into pc_o. Trap numbers 0 to 15 use vectors 32 to 47, so trap n reads its handler at byte address 128+4n.
- R5: busy_o rises on the edge that accepts a request. It stays high for exactly 5 cycles for an entry and 3 cycles for a return, and falls on the edge that loads pc_o.
- R6: While busy_o is high, exception and return requests are ignored. The results of the running sequence are unaffected.
- R7: A return with stack pointer X loads sr_o from X, loads pc_o from X+2 (high) and X+4 (low), and leaves ssp_o at X+6.
- R8: A return request while sr_o bit 13 is 0 is rejected. priv_viol_o pulses high for one cycle, busy_o stays low, and sr_o, pc_o and ssp_o do not change.
- R9: rst_req_i aborts any running sequence. On the next edge sr_o becomes 16'h2700 and the 4-cycle initialization of R1 restarts.
- R10: If an exception request and a return request arrive together while idle, the exception is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_req_i | input | 1 | Synchronous reset request, highest priority |
| exc_req_i | input | 1 | Exception request |
| exc_vec_i | input | 8 | Vector number of the exception |
| ret_req_i | input | 1 | Return-from-handler request |
| mem_req_o | output | 1 | Memory word access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid in the same cycle |
| sr_o | output | 16 | Status register |
| pc_o | output | 32 | Program counter |
| ssp_o | output | 32 | Supervisor stack pointer |
| busy_o | output | 1 | Sequence in progress |
| priv_viol_o | output | 1 | One-cycle pulse on a rejected return |

## Verification
The SR change on entry, the rejection pulse and the reset-request effect are each due one edge after the request. PC, SSP and the restored SR are due on the edge that drops busy_o: 5 edges after an accepted entry, 3 after a return, and 4 after reset. The bench drives inputs on falling edges and samples on falling edges. It counts the falling edges during which busy_o is high, compares that count with the expected length, and only then compares registers and memory with values computed from its own model of the stack.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned LONG_W = 2 * WORD_W;
  localparam int unsigned SR_S_BIT = 13;
  localparam int unsigned SR_T_BIT = 15;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RS_SH, ST_RS_SL, ST_RS_PH, ST_RS_PL,
    ST_PU_PL, ST_PU_PH, ST_PU_SR,
    ST_VC_H,  ST_VC_L,
    ST_PO_SR, ST_PO_PH, ST_PO_PL
  } seq_st_e;
endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    rst_req_i,
  input  logic    exc_req_i,
  input  logic    ret_req_i,
  input  logic    s_bit_i,
  output seq_st_e st_o,
  output logic    acc_exc_o,
  output logic    rej_ret_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    acc_exc_o = 1'b0;
    rej_ret_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (exc_req_i) begin
          acc_exc_o = 1'b1;
          st_d      = ST_PU_PL;
        end else if (ret_req_i) begin
          if (s_bit_i) st_d = ST_PO_SR;
          else         rej_ret_o = 1'b1;
        end
      end
      ST_RS_SH: st_d = ST_RS_SL;
      ST_RS_SL: st_d = ST_RS_PH;
      ST_RS_PH: st_d = ST_RS_PL;
      ST_RS_PL: st_d = ST_IDLE;
      ST_PU_PL: st_d = ST_PU_PH;
      ST_PU_PH: st_d = ST_PU_SR;
      ST_PU_SR: st_d = ST_VC_H;
      ST_VC_H:  st_d = ST_VC_L;
      ST_VC_L:  st_d = ST_IDLE;
      ST_PO_SR: st_d = ST_PO_PH;
      ST_PO_PH: st_d = ST_PO_PL;
      ST_PO_PL: st_d = ST_IDLE;
      default:  st_d = ST_RS_SH;
    endcase
    // reset request overrides everything
    if (rst_req_i) begin
      st_d      = ST_RS_SH;
      acc_exc_o = 1'b0;
      rej_ret_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RS_SH;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/exc_seq_agu.sv
module exc_seq_agu
  import exc_seq_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  seq_st_e             st_i,
  input  logic [LONG_W-1:0]   ssp_i,
  input  logic [LONG_W-1:0]   pc_i,
  input  logic [WORD_W-1:0]   tmp_sr_i,
  input  logic [VEC_W-1:0]    vec_i,
  output logic                req_o,
  output logic                we_o,
  output logic [LONG_W-1:0]   addr_o,
  output logic [WORD_W-1:0]   wdata_o
);
  logic [LONG_W-1:0] vec_base;
  assign vec_base = {{(LONG_W-VEC_W-2){1'b0}}, vec_i, 2'b00};

  always_comb begin
    req_o   = 1'b1;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (st_i)
      ST_RS_SH: addr_o = LONG_W'(0);
      ST_RS_SL: addr_o = LONG_W'(2);
      ST_RS_PH: addr_o = LONG_W'(4);
      ST_RS_PL: addr_o = LONG_W'(6);
      ST_PU_PL: begin we_o = 1'b1; addr_o = ssp_i - LONG_W'(2); wdata_o = pc_i[WORD_W-1:0]; end
      ST_PU_PH: begin we_o = 1'b1; addr_o = ssp_i - LONG_W'(4); wdata_o = pc_i[LONG_W-1:WORD_W]; end
      // ssp already lowered by 4 here
      ST_PU_SR: begin we_o = 1'b1; addr_o = ssp_i - LONG_W'(2); wdata_o = tmp_sr_i; end
      ST_VC_H:  addr_o = vec_base;
      ST_VC_L:  addr_o = vec_base + LONG_W'(2);
      ST_PO_SR: addr_o = ssp_i;
      ST_PO_PH: addr_o = ssp_i;
      ST_PO_PL: addr_o = ssp_i + LONG_W'(2);
      default:  req_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_seq_pkg::*;
#(
  parameter int unsigned           VEC_W  = 8,
  parameter logic [WORD_W-1:0]     SR_RST = 16'h2700
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rst_req_i,
  input  logic                 exc_req_i,
  input  logic [VEC_W-1:0]     exc_vec_i,
  input  logic                 ret_req_i,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [LONG_W-1:0]    mem_addr_o,
  output logic [WORD_W-1:0]    mem_wdata_o,
  input  logic [WORD_W-1:0]    mem_rdata_i,
  output logic [WORD_W-1:0]    sr_o,
  output logic [LONG_W-1:0]    pc_o,
  output logic [LONG_W-1:0]    ssp_o,
  output logic                 busy_o,
  output logic                 priv_viol_o
);
  seq_st_e           st;
  logic              acc_exc, rej_ret;
  logic [WORD_W-1:0] sr_q, tmp_sr_q, hold_q;
  logic [LONG_W-1:0] pc_q, ssp_q;
  logic [VEC_W-1:0]  vec_q;
  logic              viol_q;

  exc_seq_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_req_i (rst_req_i),
    .exc_req_i (exc_req_i),
    .ret_req_i (ret_req_i),
    .s_bit_i   (sr_q[SR_S_BIT]),
    .st_o      (st),
    .acc_exc_o (acc_exc),
    .rej_ret_o (rej_ret)
  );

  exc_seq_agu #(.VEC_W(VEC_W)) u_agu (
    .st_i     (st),
    .ssp_i    (ssp_q),
    .pc_i     (pc_q),
    .tmp_sr_i (tmp_sr_q),
    .vec_i    (vec_q),
    .req_o    (mem_req_o),
    .we_o     (mem_we_o),
    .addr_o   (mem_addr_o),
    .wdata_o  (mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= SR_RST;
      tmp_sr_q <= '0;
      hold_q   <= '0;
      pc_q     <= '0;
      ssp_q    <= '0;
      vec_q    <= '0;
      viol_q   <= 1'b0;
    end else begin
      viol_q <= rej_ret;
      if (rst_req_i) begin
        sr_q <= SR_RST;
      end else begin
        unique case (st)
          ST_IDLE: if (acc_exc) begin
            tmp_sr_q         <= sr_q;
            sr_q[SR_S_BIT]   <= 1'b1;
            sr_q[SR_T_BIT]   <= 1'b0;
            vec_q            <= exc_vec_i;
          end
          ST_RS_SH, ST_RS_PH, ST_VC_H, ST_PO_PH: hold_q <= mem_rdata_i;
          ST_RS_SL: ssp_q <= {hold_q, mem_rdata_i};
          ST_RS_PL, ST_VC_L: pc_q <= {hold_q, mem_rdata_i};
          ST_PU_PH: ssp_q <= ssp_q - LONG_W'(4);
          ST_PU_SR: ssp_q <= ssp_q - LONG_W'(2);
          ST_PO_SR: begin
            sr_q  <= mem_rdata_i;
            ssp_q <= ssp_q + LONG_W'(2);
          end
          ST_PO_PL: begin
            pc_q  <= {hold_q, mem_rdata_i};
            ssp_q <= ssp_q + LONG_W'(4);
          end
          default: ;
        endcase
      end
    end
  end

  assign sr_o        = sr_q;
  assign pc_o        = pc_q;
  assign ssp_o       = ssp_q;
  assign busy_o      = (st != ST_IDLE);
  assign priv_viol_o = viol_q;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk
  import exc_seq_pkg::*;
#(
  parameter logic [WORD_W-1:0] SR_RST = 16'h2700
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rst_req_i,
  input logic              exc_req_i,
  input logic              ret_req_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [WORD_W-1:0] sr_o,
  input logic              busy_o,
  input logic              priv_viol_o
);
  logic [3:0] run_q;
  logic       rst_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= '0;
      rst_seen_q <= 1'b0;
    end else begin
      if (busy_o) run_q <= (run_q == 4'hF) ? run_q : run_q + 4'd1;
      else        run_q <= '0;
      if (rst_req_i)   rst_seen_q <= 1'b1;
      else if (!busy_o) rst_seen_q <= 1'b0;
    end
  end

  a_r2_enter_supervisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && exc_req_i && !rst_req_i) |=> (busy_o && sr_o[SR_S_BIT] && !sr_o[SR_T_BIT]));

  a_r3_write_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_req_o && busy_o));

  a_r5_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !rst_seen_q) |-> (run_q >= 4'd3 && run_q <= 4'd5));

  a_r6_no_reject_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !priv_viol_o);

  a_r8_user_return_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && ret_req_i && !exc_req_i && !rst_req_i && !sr_o[SR_S_BIT]) |=> (priv_viol_o && !busy_o));

  a_r9_reset_preempts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> (busy_o && sr_o == SR_RST));
endmodule

bind exc_seq exc_seq_chk #(.SR_RST(SR_RST)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rst_req_i   (rst_req_i),
  .exc_req_i   (exc_req_i),
  .ret_req_i   (ret_req_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .sr_o        (sr_o),
  .busy_o      (busy_o),
  .priv_viol_o (priv_viol_o)
);

// File: tb/exc_seq_test.sv
module exc_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_req = 1'b0, exc_req = 1'b0, ret_req = 1'b0;
  logic [7:0]  exc_vec = '0;
  logic        mem_req, mem_we, busy, priv_viol;
  logic [31:0] mem_addr, pc, ssp;
  logic [15:0] mem_wdata, mem_rdata, sr;
  logic [15:0] mem [0:1023];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  exc_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .rst_req_i(rst_req), .exc_req_i(exc_req),
    .exc_vec_i(exc_vec), .ret_req_i(ret_req), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .sr_o(sr), .pc_o(pc), .ssp_o(ssp), .busy_o(busy), .priv_viol_o(priv_viol)
  );

  assign mem_rdata = mem[mem_addr[10:1]];
  always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[10:1]] <= mem_wdata;

  // op bit 8: 1 = return, 0 = exception with vector in bits 7:0
  localparam logic [8:0] OPS [0:7] = '{9'h020, 9'h02F, 9'h019, 9'h100,
                                        9'h100, 9'h01F, 9'h100, 9'h100};

  function automatic logic [31:0] handler(input logic [7:0] v);
    return {8'h00, v, v, 8'h10};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 50) begin n++; @(negedge clk); end
  endtask

  task automatic do_exc(input logic [7:0] v, output int n);
    exc_vec = v; exc_req = 1'b1;
    @(negedge clk); exc_req = 1'b0;
    wait_idle(n);
  endtask

  task automatic do_ret(output int n);
    ret_req = 1'b1;
    @(negedge clk); ret_req = 1'b0;
    wait_idle(n);
  endtask

  task automatic exc_checked(input logic [7:0] v);
    logic [31:0] pc0, ssp0; logic [15:0] sr0; int n;
    pc0 = pc; ssp0 = ssp; sr0 = sr;
    do_exc(v, n);
    chk("R5 entry busy cycles", n, 5);
    chk("R4 handler pc", pc, handler(v));
    chk("R2 sr after entry", {16'h0, sr}, {16'h0, (sr0 | 16'h2000) & 16'h7FFF});
    chk("R3 ssp after entry", ssp, ssp0 - 6);
    chk("R3 pc high word", {16'h0, mem[(ssp0-4)>>1]}, {16'h0, pc0[31:16]});
    chk("R3 pc low word", {16'h0, mem[(ssp0-2)>>1]}, {16'h0, pc0[15:0]});
    chk("R3 saved sr", {16'h0, mem[(ssp0-6)>>1]}, {16'h0, sr0});
  endtask

  task automatic ret_checked();
    logic [31:0] ssp0, epc; logic [15:0] esr; int n;
    ssp0 = ssp;
    esr = mem[ssp0>>1];
    epc = {mem[(ssp0+2)>>1], mem[(ssp0+4)>>1]};
    do_ret(n);
    chk("R5 return busy cycles", n, 3);
    chk("R7 restored sr", {16'h0, sr}, {16'h0, esr});
    chk("R7 restored pc", pc, epc);
    chk("R7 ssp after return", ssp, ssp0 + 6);
  endtask

  initial begin
    #(8*100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] s0, p0; logic [15:0] r0;
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
    for (int v = 2; v < 256; v++) begin
      mem[2*v]   = {8'h00, 8'(v)};
      mem[2*v+1] = {8'(v), 8'h10};
    end
    mem[0] = 16'h0000; mem[1] = 16'h0700;
    mem[2] = 16'h0000; mem[3] = 16'h0100;

    // R1: reset state and initialization sequence
    repeat (2) @(negedge clk);
    chk("R1 sr in reset", {16'h0, sr}, 32'h2700);
    chk("R1 busy in reset", {31'h0, busy}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    wait_idle(n);
    chk("R1 init busy cycles", n + 1, 4);
    chk("R1 ssp loaded", ssp, 32'h0700);
    chk("R1 pc loaded", pc, 32'h0100);
    chk("R1 sr after init", {16'h0, sr}, 32'h2700);

    // table walk: traps 0 and 15 (R4), nesting and unwinding
    foreach (OPS[i]) begin
      if (OPS[i][8]) ret_checked();
      else           exc_checked(OPS[i][7:0]);
    end
    chk("R7 back to start ssp", ssp, 32'h0700);
    chk("R7 back to start pc", pc, 32'h0100);

    // R6: requests during a running entry are ignored
    exc_vec = 8'd40; exc_req = 1'b1;
    @(negedge clk);
    exc_vec = 8'd50; ret_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    exc_req = 1'b0; ret_req = 1'b0;
    wait_idle(n);
    chk("R6 pc unaffected", pc, handler(8'd40));
    chk("R6 ssp unaffected", ssp, 32'h06FA);
    chk("R6 no violation", {31'h0, priv_viol}, 0);
    ret_checked();

    // R10: simultaneous exception and return
    exc_vec = 8'd33; exc_req = 1'b1; ret_req = 1'b1;
    @(negedge clk); exc_req = 1'b0; ret_req = 1'b0;
    wait_idle(n);
    chk("R10 entry taken busy", n, 5);
    chk("R10 entry taken pc", pc, handler(8'd33));
    ret_checked();

    // R8: return into user mode with trace set, then a rejected return
    mem[32'h700>>1] = 16'h8005; mem[32'h702>>1] = 16'h0000; mem[32'h704>>1] = 16'h0200;
    ret_checked();
    s0 = ssp; p0 = pc; r0 = sr;
    ret_req = 1'b1;
    @(negedge clk); ret_req = 1'b0;
    chk("R8 violation pulse", {31'h0, priv_viol}, 1);
    chk("R8 stays idle", {31'h0, busy}, 0);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'h0, priv_viol}, 0);
    chk("R8 sr unchanged", {16'h0, sr}, {16'h0, r0});
    chk("R8 pc unchanged", pc, p0);
    chk("R8 ssp unchanged", ssp, s0);
    // R2: entry from user mode with trace bit set
    exc_checked(8'd36);
    chk("R2 user entry sr", {16'h0, sr}, 32'h2005);

    // R9: reset request in the middle of an entry
    exc_vec = 8'd37; exc_req = 1'b1;
    @(negedge clk); exc_req = 1'b0;
    @(negedge clk);
    rst_req = 1'b1;
    @(negedge clk); rst_req = 1'b0;
    chk("R9 sr forced", {16'h0, sr}, 32'h2700);
    chk("R9 busy after request", {31'h0, busy}, 1);
    wait_idle(n);
    chk("R9 init length", n, 4);
    chk("R9 ssp reloaded", ssp, 32'h0700);
    chk("R9 pc reloaded", pc, 32'h0100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule